// File: doc/BRIEF.md
# Programmable Almost-Empty / Almost-Full Flag Generator

This block produces the two programmable threshold flags of a dual-clock FIFO. It watches the write and read pointers as seen from each clock domain, together with two offsets, and drives an active-low almost-empty flag and an active-low almost-full flag. Almost-empty is measured from the empty end of the storage: it asserts once the number of stored words is at or below the empty offset. Almost-full is measured from the full end: it asserts once the number of free locations is at or below the full offset. The FIFO storage, the pointer counters and the pointer synchronisers sit outside this block. The surrounding FIFO hands in both each domain's own pointer and the already synchronised copy of the other domain's pointer.

Each flag can run in one of two timing schemes, selected by a mode input that is captured only while master reset is held. In the synchronous scheme each flag is a plain register clocked by the port it belongs to: almost-empty by the read clock and almost-full by the write clock. In the asynchronous scheme each flag is asserted by one clock and released by the other. Almost-empty is asserted by a read-clock edge and released by a write-clock edge. Almost-full is asserted by a write-clock edge and released by a read-clock edge. Each release decision uses the releasing domain's own pointer view. A partial reset puts the flags into their empty-FIFO state but leaves the captured mode unchanged.

Top module: `almost_flag_gen`

## Requirements
- R1: Occupancy is (write pointer − read pointer) modulo 2^(ADDR_W+1). With the synchronous scheme, almostEmptyN is 0 exactly when the read-domain occupancy (wrPtrRd − rdPtrRd) is less than or equal to emptyOffset, and 1 otherwise.
- R2: Free space is 2^ADDR_W minus occupancy. With the synchronous scheme, almostFullN is 0 exactly when the write-domain free space (computed from wrPtrWr − rdPtrWr) is less than or equal to fullOffset, and 1 otherwise.
- R3: asyncModeSel is sampled only while masterRstN is 0. A value of 1 selects the asynchronous scheme and 0 the synchronous scheme. Changes on asyncModeSel while masterRstN is 1 have no effect on flag behaviour.
- R4: With the synchronous scheme, almostEmptyN depends only on the read-domain pointer pair and is updated on rdClk. almostFullN depends only on the write-domain pointer pair and is updated on wrClk.
- R5: With the asynchronous scheme, almostEmptyN is driven to 0 on an rdClk edge where the read-domain occupancy is ≤ emptyOffset. It returns to 1 only on a wrClk edge where the write-domain occupancy is > emptyOffset. An rdClk edge never releases it.
- R6: With the asynchronous scheme, almostFullN is driven to 0 on a wrClk edge where the write-domain free space is ≤ fullOffset. It returns to 1 only on an rdClk edge where the read-domain free space is > fullOffset. A wrClk edge never releases it.
- R7: While masterRstN is 0, almostEmptyN is 0 and almostFullN is 1, whatever the pointers and offsets.
- R8: While partialRstN is 0, within two cycles of each clock the flags reach the empty-FIFO state: almostEmptyN = 0 and almostFullN = 1. The captured scheme is kept across the partial reset.
- R9: The occupancy and free-space comparisons stay correct when the write pointer has wrapped past the top of its range and is numerically smaller than the read pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-port clock |
| rdClk | input | 1 | Read-port clock |
| masterRstN | input | 1 | Master reset, active low, asynchronous assertion; scheme is captured while low |
| partialRstN | input | 1 | Partial reset, active low, sampled by each clock |
| asyncModeSel | input | 1 | Flag timing scheme request: 1 asynchronous, 0 synchronous |
| wrPtrWr | input | ADDR_W+1 | Write pointer in the write domain |
| rdPtrWr | input | ADDR_W+1 | Read pointer synchronised into the write domain |
| rdPtrRd | input | ADDR_W+1 | Read pointer in the read domain |
| wrPtrRd | input | ADDR_W+1 | Write pointer synchronised into the read domain |
| emptyOffset | input | ADDR_W | Almost-empty threshold, in words above empty |
| fullOffset | input | ADDR_W | Almost-full threshold, in free locations below full |
| almostEmptyN | output | 1 | Almost-empty flag, active low |
| almostFullN | output | 1 | Almost-full flag, active low |

## Verification
The bench probes both flags exactly at their thresholds and one step past them, at completely full and empty, and with a wrapped write pointer. An off-by-one compare or a missing wrap bit shows up there as a flag that is one word late or inverted. In the asynchronous scheme the bench makes the two domains disagree on purpose. A design that released a flag from the wrong clock, or updated it like the synchronous scheme, would drop the flag early in those cases. The bench toggles the mode input outside master reset and then applies partial reset. A design that re-sampled the mode there would switch schemes and be caught by the same disagreeing stimulus.

// File: rtl/almost_flag_pkg.sv
package almost_flag_pkg;

  // Per-domain strobes from control to datapath
  typedef struct packed {
    logic asyncMode;    // flag set on one clock, released on the other
    logic partialHold;  // partial reset active in this domain
  } flagStrobe_t;

endpackage

// File: rtl/almost_flag_ctrl.sv
module almost_flag_ctrl
  import almost_flag_pkg::*;
(
  input  logic        rdClk,
  input  logic        wrClk,
  input  logic        masterRstN,
  input  logic        partialRstN,
  input  logic        asyncModeSel,
  output flagStrobe_t rdStrobe,
  output flagStrobe_t wrStrobe
);

  logic modeRd;
  logic modeWr;

  // Scheme is only loaded while master reset is held (clocks running)
  always_ff @(posedge rdClk) begin
    if (!masterRstN) modeRd <= asyncModeSel;
  end

  always_ff @(posedge wrClk) begin
    if (!masterRstN) modeWr <= asyncModeSel;
  end

  always_comb begin
    rdStrobe.asyncMode   = modeRd;
    rdStrobe.partialHold = !partialRstN;
    wrStrobe.asyncMode   = modeWr;
    wrStrobe.partialHold = !partialRstN;
  end

  // R3: captured scheme never moves outside master reset
  a_r3_mode_held_rd: assert property (@(posedge rdClk) disable iff (!masterRstN)
    masterRstN |=> $stable(modeRd));
  a_r3_mode_held_wr: assert property (@(posedge wrClk) disable iff (!masterRstN)
    masterRstN |=> $stable(modeWr));

endmodule

// File: rtl/almost_flag_datapath.sv
module almost_flag_datapath
  import almost_flag_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              rdClk,
  input  logic              wrClk,
  input  logic              masterRstN,
  input  flagStrobe_t       rdStrobe,
  input  flagStrobe_t       wrStrobe,
  input  logic [ADDR_W:0]   wrPtrWr,
  input  logic [ADDR_W:0]   rdPtrWr,
  input  logic [ADDR_W:0]   rdPtrRd,
  input  logic [ADDR_W:0]   wrPtrRd,
  input  logic [ADDR_W-1:0] emptyOffset,
  input  logic [ADDR_W-1:0] fullOffset,
  output logic              almostEmptyN,
  output logic              almostFullN
);

  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PTR_W-1:0] DEPTH_P = DEPTH[PTR_W-1:0];

  logic [PTR_W-1:0] occRd, occWr, freeRd, freeWr;
  logic [PTR_W-1:0] emptyOffW, fullOffW;
  logic aeHitRd, aeClearWr, afHitWr, afClearRd;

  always_comb begin
    occRd     = wrPtrRd - rdPtrRd;
    occWr     = wrPtrWr - rdPtrWr;
    freeRd    = DEPTH_P - occRd;
    freeWr    = DEPTH_P - occWr;
    emptyOffW = {1'b0, emptyOffset};
    fullOffW  = {1'b0, fullOffset};
    aeHitRd   = (occRd <= emptyOffW);
    aeClearWr = (occWr >  emptyOffW);
    afHitWr   = (freeWr <= fullOffW);
    afClearRd = (freeRd >  fullOffW);
  end

  // Synchronous scheme: one register per flag in its own domain
  logic aeSync, afSync;
  // Asynchronous scheme: flag is asserted while the two halves differ
  logic aeRdTog, aeWrTog, afRdTog, afWrTog;
  logic aeLowAsync, afLowAsync;

  always_comb begin
    aeLowAsync = (aeRdTog != aeWrTog);
    afLowAsync = (afRdTog != afWrTog);
  end

  always_ff @(posedge rdClk or negedge masterRstN) begin
    if (!masterRstN) begin
      aeSync  <= 1'b0;
      aeRdTog <= 1'b1;
      afRdTog <= 1'b0;
    end else begin
      aeSync <= rdStrobe.partialHold ? 1'b0 : !aeHitRd;
      if (rdStrobe.asyncMode) begin
        // read side: may assert almost-empty, may release almost-full
        if (!aeLowAsync && (aeHitRd || rdStrobe.partialHold))
          aeRdTog <= !aeRdTog;
        if (afLowAsync && (afClearRd || rdStrobe.partialHold))
          afRdTog <= !afRdTog;
      end
    end
  end

  always_ff @(posedge wrClk or negedge masterRstN) begin
    if (!masterRstN) begin
      afSync  <= 1'b1;
      aeWrTog <= 1'b0;
      afWrTog <= 1'b0;
    end else begin
      afSync <= wrStrobe.partialHold ? 1'b1 : !afHitWr;
      if (wrStrobe.asyncMode && !wrStrobe.partialHold) begin
        // write side: may release almost-empty, may assert almost-full
        if (aeLowAsync && aeClearWr)
          aeWrTog <= !aeWrTog;
        if (!afLowAsync && afHitWr)
          afWrTog <= !afWrTog;
      end
    end
  end

  always_comb begin
    almostEmptyN = rdStrobe.asyncMode ? !aeLowAsync : aeSync;
    almostFullN  = wrStrobe.asyncMode ? !afLowAsync : afSync;
  end

  // R7: reset values on the outputs
  always @(posedge rdClk) begin
    if (!masterRstN) begin
      a_r7_reset_flags_rd: assert (!almostEmptyN && almostFullN);
    end
  end
  always @(posedge wrClk) begin
    if (!masterRstN) begin
      a_r7_reset_flags_wr: assert (!almostEmptyN && almostFullN);
    end
  end

  // R4: synchronous scheme follows own-domain threshold one edge later
  a_r4_sync_ae: assert property (@(posedge rdClk) disable iff (!masterRstN)
    (!rdStrobe.asyncMode && !rdStrobe.partialHold) |=> (almostEmptyN == !$past(aeHitRd)));
  a_r4_sync_af: assert property (@(posedge wrClk) disable iff (!masterRstN)
    (!wrStrobe.asyncMode && !wrStrobe.partialHold) |=> (almostFullN == !$past(afHitWr)));

  // R8: partial reset drives the empty-FIFO flag state
  a_r8_partial_ae: assert property (@(posedge rdClk) disable iff (!masterRstN)
    (rdStrobe.partialHold && $past(rdStrobe.partialHold)) |-> !almostEmptyN);
  a_r8_partial_af_async: assert property (@(posedge rdClk) disable iff (!masterRstN)
    (rdStrobe.asyncMode && rdStrobe.partialHold && $past(rdStrobe.partialHold)) |-> almostFullN);
  a_r8_partial_af_sync: assert property (@(posedge wrClk) disable iff (!masterRstN)
    (!wrStrobe.asyncMode && wrStrobe.partialHold && $past(wrStrobe.partialHold)) |-> almostFullN);

endmodule

// File: rtl/almost_flag_gen.sv
module almost_flag_gen
  import almost_flag_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              masterRstN,
  input  logic              partialRstN,
  input  logic              asyncModeSel,
  input  logic [ADDR_W:0]   wrPtrWr,
  input  logic [ADDR_W:0]   rdPtrWr,
  input  logic [ADDR_W:0]   rdPtrRd,
  input  logic [ADDR_W:0]   wrPtrRd,
  input  logic [ADDR_W-1:0] emptyOffset,
  input  logic [ADDR_W-1:0] fullOffset,
  output logic              almostEmptyN,
  output logic              almostFullN
);

  flagStrobe_t rdStrobe;
  flagStrobe_t wrStrobe;

  almost_flag_ctrl u_ctrl (
    .rdClk        (rdClk),
    .wrClk        (wrClk),
    .masterRstN   (masterRstN),
    .partialRstN  (partialRstN),
    .asyncModeSel (asyncModeSel),
    .rdStrobe     (rdStrobe),
    .wrStrobe     (wrStrobe)
  );

  almost_flag_datapath #(.ADDR_W(ADDR_W)) u_datapath (
    .rdClk        (rdClk),
    .wrClk        (wrClk),
    .masterRstN   (masterRstN),
    .rdStrobe     (rdStrobe),
    .wrStrobe     (wrStrobe),
    .wrPtrWr      (wrPtrWr),
    .rdPtrWr      (rdPtrWr),
    .rdPtrRd      (rdPtrRd),
    .wrPtrRd      (wrPtrRd),
    .emptyOffset  (emptyOffset),
    .fullOffset   (fullOffset),
    .almostEmptyN (almostEmptyN),
    .almostFullN  (almostFullN)
  );

endmodule

// File: tb/almost_flag_gen_bench.sv
module almost_flag_gen_bench;

  localparam int CLK_PERIOD = 20;
  localparam int ADDR_W = 4;
  localparam int PTR_W = ADDR_W + 1;

  typedef struct packed {
    logic [PTR_W-1:0]  wr;
    logic [PTR_W-1:0]  rd;
    logic [ADDR_W-1:0] eo;
    logic [ADDR_W-1:0] fo;
    logic              ae;
    logic              af;
  } vec_t;

  // synchronous-scheme table; both domain views carry the same pointers
  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{5'd0,  5'd0,  4'd2,  4'd2, 1'b0, 1'b1},  // empty
    '{5'd2,  5'd0,  4'd2,  4'd2, 1'b0, 1'b1},  // R1 boundary
    '{5'd3,  5'd0,  4'd2,  4'd2, 1'b1, 1'b1},  // R1 one past
    '{5'd14, 5'd0,  4'd2,  4'd2, 1'b1, 1'b0},  // R2 boundary
    '{5'd13, 5'd0,  4'd2,  4'd2, 1'b1, 1'b1},  // R2 one before
    '{5'd16, 5'd0,  4'd0,  4'd0, 1'b1, 1'b0},  // completely full
    '{5'd15, 5'd0,  4'd0,  4'd0, 1'b1, 1'b1},  // one free, zero offset
    '{5'd3,  5'd20, 4'd15, 4'd1, 1'b0, 1'b0},  // R9 wrapped, occupancy 15
    '{5'd1,  5'd0,  4'd0,  4'd5, 1'b1, 1'b1}   // one word, zero offset
  };

  logic wrClk, rdClk, masterRstN, partialRstN, asyncModeSel;
  logic [PTR_W-1:0] wrPtrWr, rdPtrWr, rdPtrRd, wrPtrRd;
  logic [ADDR_W-1:0] emptyOffset, fullOffset;
  logic almostEmptyN, almostFullN;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  almost_flag_gen #(.ADDR_W(ADDR_W)) u_almost_flag_gen (
    .wrClk(wrClk), .rdClk(rdClk), .masterRstN(masterRstN),
    .partialRstN(partialRstN), .asyncModeSel(asyncModeSel),
    .wrPtrWr(wrPtrWr), .rdPtrWr(rdPtrWr), .rdPtrRd(rdPtrRd), .wrPtrRd(wrPtrRd),
    .emptyOffset(emptyOffset), .fullOffset(fullOffset),
    .almostEmptyN(almostEmptyN), .almostFullN(almostFullN)
  );

  initial begin
    wrClk = 1'b0;
    forever #(CLK_PERIOD/2) wrClk = !wrClk;
  end

  initial begin
    rdClk = 1'b0;
    #(CLK_PERIOD/4);
    forever #(CLK_PERIOD/2) rdClk = !rdClk;
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // wait n read cycles, land 3 time units after a read edge
  task automatic waitRd(input int n);
    repeat (n) @(posedge rdClk);
    #3;
  endtask

  // write-domain view occupancy occW, read-domain view occupancy occR
  task automatic setViews(input int occW, input int occR);
    rdPtrWr = '0;
    rdPtrRd = '0;
    wrPtrWr = PTR_W'(occW);
    wrPtrRd = PTR_W'(occR);
  endtask

  task automatic masterReset(input logic modeVal);
    masterRstN = 1'b0;
    asyncModeSel = modeVal;
    waitRd(3);
    masterRstN = 1'b1;
    waitRd(1);
  endtask

  initial begin
    masterRstN = 1'b1;
    partialRstN = 1'b1;
    asyncModeSel = 1'b0;
    emptyOffset = 4'd2;
    fullOffset = 4'd2;
    setViews(15, 15);
    #1;
    // R7: flags forced during master reset despite near-full pointers
    masterRstN = 1'b0;
    waitRd(3);
    check("R7 ae in reset", almostEmptyN, 1'b0);
    check("R7 af in reset", almostFullN, 1'b1);
    masterRstN = 1'b1;
    asyncModeSel = 1'b1;  // R3: ignored outside master reset
    setViews(0, 0);
    waitRd(2);

    // table walk, synchronous scheme (R1, R2, R9)
    for (int i = 0; i < NVEC; i++) begin
      wrPtrWr = VECS[i].wr; wrPtrRd = VECS[i].wr;
      rdPtrWr = VECS[i].rd; rdPtrRd = VECS[i].rd;
      emptyOffset = VECS[i].eo; fullOffset = VECS[i].fo;
      waitRd(3);
      check($sformatf("R1/R9 row %0d ae", i), almostEmptyN, VECS[i].ae);
      check($sformatf("R2/R9 row %0d af", i), almostFullN, VECS[i].af);
    end

    // R4 and R3: each flag follows only its own domain's view
    emptyOffset = 4'd2; fullOffset = 4'd2;
    setViews(0, 10);
    waitRd(3);
    check("R4 ae from read view", almostEmptyN, 1'b1);
    check("R3 sync kept, af from write view", almostFullN, 1'b1);
    setViews(15, 0);
    waitRd(3);
    check("R4 ae read view empty", almostEmptyN, 1'b0);
    check("R4 af from write view", almostFullN, 1'b0);

    // asynchronous scheme
    setViews(0, 0);
    masterReset(1'b1);
    asyncModeSel = 1'b0;  // R3: must not return to synchronous
    waitRd(3);
    check("R5 ae low when empty", almostEmptyN, 1'b0);
    check("R6 af high when empty", almostFullN, 1'b1);
    setViews(0, 10);
    waitRd(4);
    check("R5 read edge does not release ae", almostEmptyN, 1'b0);
    check("R6 af stays high", almostFullN, 1'b1);
    setViews(10, 10);
    waitRd(3);
    check("R5 write edge releases ae", almostEmptyN, 1'b1);
    setViews(15, 14);
    waitRd(3);
    check("R6 write edge asserts af", almostFullN, 1'b0);
    setViews(10, 14);
    waitRd(4);
    check("R6 write edge does not release af", almostFullN, 1'b0);
    check("R5 ae stays high", almostEmptyN, 1'b1);
    setViews(10, 10);
    waitRd(3);
    check("R6 read edge releases af", almostFullN, 1'b1);

    // R8 partial reset in asynchronous scheme
    setViews(15, 14);
    waitRd(3);
    check("R8 af low before partial", almostFullN, 1'b0);
    partialRstN = 1'b0;
    asyncModeSel = 1'b0;
    setViews(0, 0);
    waitRd(3);
    check("R8 ae after partial", almostEmptyN, 1'b0);
    check("R8 af after partial", almostFullN, 1'b1);
    partialRstN = 1'b1;
    waitRd(2);
    setViews(0, 10);
    waitRd(4);
    check("R8 scheme kept across partial", almostEmptyN, 1'b0);

    // R8 partial reset in synchronous scheme
    setViews(15, 15);
    masterReset(1'b0);
    waitRd(3);
    check("R8 sync af low before partial", almostFullN, 1'b0);
    check("R8 sync ae high before partial", almostEmptyN, 1'b1);
    partialRstN = 1'b0;
    waitRd(3);
    check("R8 sync ae after partial", almostEmptyN, 1'b0);
    check("R8 sync af after partial", almostFullN, 1'b1);
    partialRstN = 1'b1;
    waitRd(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule